// File: doc/BRIEF.md
# Bayesian Weight Sampler and Gradient Unit

This block sits next to one processing element of a Bayesian network training engine. Every valid beat carries one weight's mean, standard deviation and unit Gaussian random value. From these the block forms the sampled weight and sends it to the multiply tile. In the backward phase the same beat also carries the likelihood gradient that the tile computed for that weight. The block then adds the prior/posterior derivative term, which comes from the sampled weight itself. From the result it produces the gradients for the mean and for the standard deviation.

All values are 16-bit two's-complement fixed point with 8 fractional bits. The datapath is a two-register pipeline. A phase bit travels with each beat. Two named phase states exist: `PH_FWD` (encoding 0) and `PH_BWD` (encoding 1). A beat with valid high moves the stage-1 phase register to the value on `in_phase`, and the next stage-1 beat moves the stage-2 phase register to match. Beats with valid low leave both registers unchanged. In `PH_FWD` only the sampler path produces results. In `PH_BWD` the derivative and update paths are also active. Averaging across samples, parameter storage and the optimizer live outside the block.

Top module: `bayes_wsample_grad`

## Requirements
- R1: For a valid beat, `out_weight` equals sat(mu + mul(sigma, eps)). It appears together with `out_vld` two clock edges after the beat is presented.
- R2: mul(a, b) forms the full product, adds 128 and shifts right arithmetically by 8 bits. This rounds half toward positive infinity.
- R3: Every product, sum and shift result saturates to the range -32768..32767 and never wraps.
- R4: `out_vld` is high exactly two clock edges after `in_vld` was high, and low otherwise.
- R5: In `PH_BWD`, the final weight gradient is g = sat(sat(4 * w) + lik). Here w is the sampled weight of the same beat and lik is `in_lik`.
- R6: In `PH_BWD`, `out_gmu` equals g.
- R7: In `PH_BWD`, `out_gsig` equals sat(mul(g, eps)), using the same eps that produced the weight.
- R8: In `PH_FWD` (`in_phase` = 0), `out_gmu` and `out_gsig` are 0, and `out_weight` is still produced per R1.
- R9: After reset all outputs are 0 and `out_vld` is low.
- R10: While no result is delivered (`out_vld` low), `out_weight`, `out_gmu` and `out_gsig` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Beat valid |
| in_phase | input | 1 | 0 = forward, 1 = backward |
| in_mu | input | 16 | Mean, Q8.8 |
| in_sigma | input | 16 | Standard deviation, Q8.8 |
| in_eps | input | 16 | Gaussian random value, Q8.8 |
| in_lik | input | 16 | Likelihood gradient, Q8.8 (used in backward) |
| out_vld | output | 1 | Result valid |
| out_weight | output | 16 | Sampled weight, Q8.8 |
| out_gmu | output | 16 | Mean gradient, Q8.8 |
| out_gsig | output | 16 | Standard-deviation gradient, Q8.8 |

## Verification
A forward sample of a new beat in stage 1 and the backward gradient of the previous beat in stage 2 can fall in the same cycle. The saturating weight of one beat must not leak into the gated gradients of its neighbour. To provoke this, the bench streams corner operands back to back with the phase toggling on every beat. It inserts idle gaps at intervals so that the hold behaviour is also tested. Each delivered beat is judged against an arithmetic model of R1 to R8. The bench's model pipeline tracks which phase that beat carried.

// File: rtl/bws_pkg.sv
package bws_pkg;
    typedef enum logic {
        PH_FWD = 1'b0,
        PH_BWD = 1'b1
    } phase_t;
endpackage

// File: rtl/fx_mul_rs.sv
module fx_mul_rs #(
    parameter int DW = 16,
    parameter int FW = 8
) (
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    output logic signed [DW-1:0] y
);
    localparam int PW = 2 * DW + 1;
    localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FW - 1);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;

    always_comb begin
        prod = PW'(a) * PW'(b);
        rnd  = (prod + HALF) >>> FW;
        if (rnd > MAXV) begin
            y = MAXV[DW-1:0];
        end else if (rnd < MINV) begin
            y = MINV[DW-1:0];
        end else begin
            y = rnd[DW-1:0];
        end
    end
endmodule

// File: rtl/fx_add_sat.sv
module fx_add_sat #(
    parameter int DW = 16
) (
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    output logic signed [DW-1:0] y
);
    logic signed [DW:0] s;

    always_comb begin
        s = {a[DW-1], a} + {b[DW-1], b};
        if (s[DW] != s[DW-1]) begin
            y = s[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
        end else begin
            y = s[DW-1:0];
        end
    end
endmodule

// File: rtl/fx_shl_sat.sv
module fx_shl_sat #(
    parameter int DW = 16,
    parameter int SH = 2
) (
    input  logic signed [DW-1:0] a,
    output logic signed [DW-1:0] y
);
    localparam int XW = DW + SH;
    localparam logic signed [XW-1:0] MAXV = {{(SH+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [XW-1:0] MINV = {{(SH+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [XW-1:0] ext;

    always_comb begin
        ext = {a, {SH{1'b0}}};
        if (ext > MAXV) begin
            y = MAXV[DW-1:0];
        end else if (ext < MINV) begin
            y = MINV[DW-1:0];
        end else begin
            y = ext[DW-1:0];
        end
    end
endmodule

// File: rtl/bayes_wsample_grad.sv
module bayes_wsample_grad
    import bws_pkg::*;
#(
    parameter int DW          = 16,
    parameter int FW          = 8,
    parameter int PRIOR_SHIFT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic          in_phase,
    input  logic [DW-1:0] in_mu,
    input  logic [DW-1:0] in_sigma,
    input  logic [DW-1:0] in_eps,
    input  logic [DW-1:0] in_lik,
    output logic          out_vld,
    output logic [DW-1:0] out_weight,
    output logic [DW-1:0] out_gmu,
    output logic [DW-1:0] out_gsig
);
    // stage 1: sampler
    logic signed [DW-1:0] sig_eps;
    logic signed [DW-1:0] w_next;

    fx_mul_rs #(.DW(DW), .FW(FW)) u_mul_se (
        .a(in_sigma), .b(in_eps), .y(sig_eps)
    );
    fx_add_sat #(.DW(DW)) u_add_w (
        .a(in_mu), .b(sig_eps), .y(w_next)
    );

    logic                 s1_vld;
    phase_t               s1_phase;
    logic signed [DW-1:0] s1_w;
    logic signed [DW-1:0] s1_eps;
    logic signed [DW-1:0] s1_lik;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_phase <= PH_FWD;
            s1_w     <= '0;
            s1_eps   <= '0;
            s1_lik   <= '0;
        end else begin
            s1_vld <= in_vld;
            if (in_vld) begin
                s1_phase <= phase_t'(in_phase);
                s1_w     <= w_next;
                s1_eps   <= in_eps;
                s1_lik   <= in_lik;
            end
        end
    end

    // stage 2: derivative and update paths
    logic signed [DW-1:0] prior_d;
    logic signed [DW-1:0] g_full;
    logic signed [DW-1:0] g_sig;

    fx_shl_sat #(.DW(DW), .SH(PRIOR_SHIFT)) u_prior (
        .a(s1_w), .y(prior_d)
    );
    fx_add_sat #(.DW(DW)) u_add_g (
        .a(prior_d), .b(s1_lik), .y(g_full)
    );
    fx_mul_rs #(.DW(DW), .FW(FW)) u_mul_gs (
        .a(g_full), .b(s1_eps), .y(g_sig)
    );

    phase_t               s2_phase;
    logic signed [DW-1:0] s2_w;
    logic signed [DW-1:0] s2_gmu;
    logic signed [DW-1:0] s2_gsig;

    // phase state register: follows the beat as it moves down the pipe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            s2_phase <= PH_FWD;
            s2_w     <= '0;
            s2_gmu   <= '0;
            s2_gsig  <= '0;
        end else begin
            out_vld <= s1_vld;
            if (s1_vld) begin
                s2_phase <= s1_phase;
                s2_w     <= s1_w;
                if (s1_phase == PH_BWD) begin
                    s2_gmu  <= g_full;
                    s2_gsig <= g_sig;
                end
            end
        end
    end

    // outputs decoded from phase state
    always_comb begin
        out_weight = s2_w;
        unique case (s2_phase)
            PH_FWD: begin
                out_gmu  = '0;
                out_gsig = '0;
            end
            PH_BWD: begin
                out_gmu  = s2_gmu;
                out_gsig = s2_gsig;
            end
            default: begin
                out_gmu  = '0;
                out_gsig = '0;
            end
        endcase
    end

    // assertions
    a_r4_vld_follow: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld |=> out_vld);
    a_r4_vld_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_vld |=> !out_vld);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_vld |=> ($stable(out_weight) && $stable(out_gmu) && $stable(out_gsig)));
    a_r8_fwd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s1_phase == PH_FWD) |=> (out_gmu == '0 && out_gsig == '0));
    a_r3_pos_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !in_mu[DW-1] && !sig_eps[DW-1]) |-> !w_next[DW-1]);
    a_r3_neg_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_mu[DW-1] && sig_eps[DW-1]) |-> w_next[DW-1]);
    a_r7_zero_eps: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s1_phase == PH_BWD && s1_eps == '0) |=> out_gsig == '0);
    a_r5_zero_terms: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s1_phase == PH_BWD && s1_w == '0 && s1_lik == '0) |=> out_gmu == '0);
endmodule

// File: tb/sim_bayes_wsample_grad.sv
module sim_bayes_wsample_grad;
    localparam int PERIOD   = 10;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic        in_phase = 1'b0;
    logic [15:0] in_mu = '0;
    logic [15:0] in_sigma = '0;
    logic [15:0] in_eps = '0;
    logic [15:0] in_lik = '0;
    logic        out_vld;
    logic [15:0] out_weight;
    logic [15:0] out_gmu;
    logic [15:0] out_gsig;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    bayes_wsample_grad u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_phase(in_phase),
        .in_mu(in_mu), .in_sigma(in_sigma), .in_eps(in_eps), .in_lik(in_lik),
        .out_vld(out_vld), .out_weight(out_weight), .out_gmu(out_gmu), .out_gsig(out_gsig)
    );

    function automatic int sat16(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    // R2: round half up, then R3 saturate
    function automatic int rmul(int a, int b);
        longint p;
        p = longint'(a) * longint'(b);
        p = (p + 128) >>> 8;
        return sat16(p);
    endfunction

    function automatic int corner(int k);
        case (k)
            0: return -32768;   1: return -32767;  2: return -256;
            3: return -129;     4: return -128;    5: return -1;
            6: return 0;        7: return 1;       8: return 127;
            9: return 128;      10: return 255;    11: return 256;
            12: return 1000;    default: return 32767;
        endcase
    endfunction

    // two-deep model pipe of expected results
    bit q_v[2];
    bit q_p[2];
    int q_w[2];
    int q_gm[2];
    int q_gs[2];
    int e_w = 0;
    int e_gm = 0;
    int e_gs = 0;

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_out();
        bit v;
        v = q_v[1];
        chk("R4 valid", int'(out_vld), int'(v));
        if (v) begin
            e_w = q_w[1];
            e_gm = q_gm[1];
            e_gs = q_gs[1];
            chk("R1 weight", $signed(out_weight), e_w);
            chk(q_p[1] ? "R6 mean grad" : "R8 mean grad fwd", $signed(out_gmu), e_gm);
            chk(q_p[1] ? "R7 sigma grad" : "R8 sigma grad fwd", $signed(out_gsig), e_gs);
        end else begin
            chk("R10 weight hold", $signed(out_weight), e_w);
            chk("R10 gmu hold", $signed(out_gmu), e_gm);
            chk("R10 gsig hold", $signed(out_gsig), e_gs);
        end
    endtask

    task automatic step(bit v, bit ph, int mu, int sg, int ep, int lk);
        int w;
        int d;
        int g;
        @(negedge clk);
        check_out();
        q_v[1] = q_v[0]; q_p[1] = q_p[0]; q_w[1] = q_w[0];
        q_gm[1] = q_gm[0]; q_gs[1] = q_gs[0];
        w = sat16(longint'(mu) + longint'(rmul(sg, ep)));      // R1
        d = sat16(longint'(w) * 4);                            // R5 prior term
        g = sat16(longint'(d) + longint'(lk));                 // R5
        q_v[0] = v;
        q_p[0] = ph;
        q_w[0] = w;
        q_gm[0] = ph ? g : 0;                                  // R6, R8
        q_gs[0] = ph ? rmul(g, ep) : 0;                        // R7, R8
        in_vld = v;
        in_phase = ph;
        in_mu = 16'(mu);
        in_sigma = 16'(sg);
        in_eps = 16'(ep);
        in_lik = 16'(lk);
    endtask

    initial begin
        int n;
        for (int i = 0; i < 2; i++) begin
            q_v[i] = 1'b0; q_p[i] = 1'b0; q_w[i] = 0; q_gm[i] = 0; q_gs[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk("R9 valid", int'(out_vld), 0);
        chk("R9 weight", $signed(out_weight), 0);
        chk("R9 gmu", $signed(out_gmu), 0);
        chk("R9 gsig", $signed(out_gsig), 0);

        // corner sweep: R2 rounding, R3 saturation, phase toggling each beat
        n = 0;
        for (int a = 0; a < 14; a++) begin
            for (int b = 0; b < 14; b++) begin
                for (int c = 0; c < 14; c++) begin
                    n++;
                    if (n % 11 == 0) step(1'b0, 1'b0, 0, 0, 0, 0);   // R10 gap
                    step(1'b1, n[0], corner(a), corner(b), corner(c), corner((n * 5) % 14));
                end
            end
        end

        // random beats with random gaps
        for (int i = 0; i < 20000; i++) begin
            step(($urandom_range(9) < 8), 1'($urandom_range(1)),
                 int'($urandom_range(65535)) - 32768, int'($urandom_range(65535)) - 32768,
                 int'($urandom_range(1023)) - 512, int'($urandom_range(65535)) - 32768);
        end

        // drain
        repeat (3) step(1'b0, 1'b0, 0, 0, 0, 0);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule